// File: doc/BRIEF.md
# Read Data Checker with Error Capture

This block sits beside a memory test engine and checks the data that comes back from read bursts. Each read command that the engine issues (start address and burst length) is pushed into a small in-order queue. As read beats return, the checker regenerates the expected value of each beat from its address (address-as-data: the 32-bit beat address is replicated across the data bus). It compares that value with the returned beat and presents the expected value, a valid strobe and a per-beat compare result one cycle later.

On the first mismatch the checker raises a sticky error flag. In the same cycle it captures a fixed-layout status word. The word holds the start address and length field of the failing burst, three memory-controller queue flags as seen in the failing cycle, the expected data and the read data. Later mismatches leave the captured word alone. Reset or a clear input removes both the flag and the word. Commands offered while the queue already holds `QDEPTH` bursts are dropped. The test engine is expected to pace its reads so that this does not happen.

Top module: `rd_beat_checker`

## Requirements
- R1: For each read beat accepted while a burst is pending, `exp_valid` is high on the next cycle. `exp_data` then equals the beat address replicated DW/32 times. The beat address is the burst start address plus k times DW/8, where k counts from 0 within the burst, computed modulo 2^32.
- R2: `beat_mismatch` is high in the same cycle as `exp_valid` exactly when `exp_data` differs from the read data of that beat. It is low whenever `exp_valid` is low.
- R3: Bursts are checked in the order their commands were accepted. A burst has `cmd_len` beats, and a length field of 0 means 64 beats. The beat after the last beat of a burst belongs to the next queued burst.
- R4: A read beat that arrives with no burst pending is ignored: `exp_valid` and `beat_mismatch` stay low on the next cycle.
- R5: `err_flag` rises in the cycle in which `beat_mismatch` is first high after reset or clear. It then stays high.
- R6: The status word is captured together with the rising `err_flag`, with this layout:
  - [31:0] burst start address;
  - [37:32] burst length field;
  - [40] `cmdq_full`, [41] `wrq_full` and [42] `rdq_empty`, each as sampled with the failing beat;
  - [64+DW-1:64] expected data;
  - [64+2*DW-1:64+DW] read data;
  - all other bits zero.
- R7: Mismatches that follow the first one leave `err_status` unchanged.
- R8: `clr_err` clears `err_flag` and `err_status` on the next cycle. A mismatch in the same cycle as `clr_err` still shows on `beat_mismatch` but is not captured.
- R9: After reset, `exp_valid`, `beat_mismatch` and `err_flag` are low, `err_status` is zero and no burst is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_err | input | 1 | Clears error flag and status |
| cmd_valid | input | 1 | Read command issued this cycle |
| cmd_addr | input | 32 | Read burst start address |
| cmd_len | input | 6 | Burst length in beats (0 = 64) |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | DW | Read data beat |
| cmdq_full | input | 1 | Controller command queue full flag |
| wrq_full | input | 1 | Controller write queue full flag |
| rdq_empty | input | 1 | Controller read queue empty flag |
| exp_data | output | DW | Expected data of the checked beat |
| exp_valid | output | 1 | Expected data / compare result valid |
| beat_mismatch | output | 1 | Checked beat differs from expected |
| err_flag | output | 1 | Sticky first-error flag |
| err_status | output | 64+2*DW | Captured error status word |

## Verification
Every result of the block is due exactly one clock after the beat that causes it. This covers `exp_data`, `exp_valid`, `beat_mismatch`, the rise of `err_flag` and the capture of `err_status`. A clear takes effect one clock after `clr_err` is driven. The bench drives each beat or clear at a falling edge, lets exactly one rising edge pass, and samples at the following falling edge, so each check lands in the cycle its result is due. Expected beat addresses and status words are built in the bench from the command it issued, the beat index and the flag values it drove.

// File: rtl/rd_beat_checker.sv
module rd_beat_checker #(
  parameter int DW = 64,
  parameter int QDEPTH = 4,
  localparam int LENW = 6,
  localparam int QAW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int STW = 64 + 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_err,
  input  logic          cmd_valid,
  input  logic [31:0]   cmd_addr,
  input  logic [LENW-1:0] cmd_len,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  input  logic          cmdq_full,
  input  logic          wrq_full,
  input  logic          rdq_empty,
  output logic [DW-1:0] exp_data,
  output logic          exp_valid,
  output logic          beat_mismatch,
  output logic          err_flag,
  output logic [STW-1:0] err_status
);
  localparam int REP = DW / 32;
  localparam logic [31:0] STEP = 32'(DW / 8);
  localparam logic [QAW:0] QFULL = (QAW + 1)'(QDEPTH);

  logic [31:0]     q_addr [QDEPTH];
  logic [LENW-1:0] q_len  [QDEPTH];
  logic [QAW-1:0]  wr_ptr, rd_ptr;
  logic [QAW:0]    q_cnt;
  logic [LENW:0]   beat_idx;

  logic            have, take, push, last;
  logic [31:0]     head_addr, beat_addr;
  logic [LENW-1:0] head_len;
  logic [LENW:0]   beats;
  logic [DW-1:0]   exp_now;
  logic            diff_now;

  assign have      = q_cnt != '0;
  assign take      = rd_valid && have;
  assign push      = cmd_valid && (q_cnt != QFULL);
  assign head_addr = q_addr[rd_ptr];
  assign head_len  = q_len[rd_ptr];
  assign beats     = (head_len == '0) ? (LENW + 1)'(1 << LENW) : {1'b0, head_len};
  assign last      = beat_idx == beats - 1'b1;
  assign beat_addr = head_addr + 32'(beat_idx) * STEP;
  assign exp_now   = {REP{beat_addr}};
  assign diff_now  = exp_now != rd_data;

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wr_ptr] <= cmd_addr;
      q_len[wr_ptr]  <= cmd_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      q_cnt    <= '0;
      beat_idx <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == QAW'(QDEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (take) begin
        if (last) begin
          beat_idx <= '0;
          rd_ptr   <= (rd_ptr == QAW'(QDEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end else begin
          beat_idx <= beat_idx + 1'b1;
        end
      end
      q_cnt <= q_cnt + (QAW + 1)'(push) - (QAW + 1)'(take && last);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_valid     <= 1'b0;
      beat_mismatch <= 1'b0;
      exp_data      <= '0;
    end else begin
      exp_valid     <= take;
      beat_mismatch <= take && diff_now;
      if (take) exp_data <= exp_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_err) begin
      err_flag   <= 1'b0;
      err_status <= '0;
    end else if (take && diff_now && !err_flag) begin
      err_flag   <= 1'b1;
      err_status <= {rd_data, exp_now, 21'b0, rdq_empty, wrq_full, cmdq_full,
                     2'b0, head_len, head_addr};
    end
  end
endmodule

module rd_beat_checker_sva #(
  parameter int DW = 64,
  localparam int STW = 64 + 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_err,
  input logic          rd_valid,
  input logic          pending,
  input logic [DW-1:0] exp_data,
  input logic          exp_valid,
  input logic          beat_mismatch,
  input logic          err_flag,
  input logic [STW-1:0] err_status
);
  a_r1_valid_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && pending |=> exp_valid);
  a_r4_no_valid_without_work: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && pending) |=> !exp_valid);
  a_r2_mismatch_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    beat_mismatch |-> exp_valid);
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !clr_err |=> err_flag);
  a_r5_flag_rises_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> beat_mismatch);
  a_r7_status_held: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !clr_err |=> $stable(err_status));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> !err_flag && err_status == '0);
  a_r6_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
    err_status[39:38] == 2'b0 && err_status[63:43] == 21'b0);
  a_r6_status_only_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag |-> err_status == '0);
endmodule

bind rd_beat_checker rd_beat_checker_sva #(.DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .rd_valid(rd_valid),
  .pending(have), .exp_data(exp_data), .exp_valid(exp_valid),
  .beat_mismatch(beat_mismatch), .err_flag(err_flag), .err_status(err_status));

// File: tb/rd_beat_checker_test.sv
module rd_beat_checker_test;
  localparam int DW = 64;
  localparam int STW = 64 + 2 * DW;

  logic clk = 1'b0, rst_n = 1'b0, clr_err = 1'b0;
  logic cmd_valid = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [5:0] cmd_len = '0;
  logic rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic cmdq_full = 1'b0, wrq_full = 1'b0, rdq_empty = 1'b0;
  logic [DW-1:0] exp_data;
  logic exp_valid, beat_mismatch, err_flag;
  logic [STW-1:0] err_status;

  int checks = 0, errors = 0, cyc = 0;

  rd_beat_checker #(.DW(DW), .QDEPTH(4)) uut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [DW-1:0] model(input logic [31:0] a, input int k);
    logic [31:0] b = a + 32'(k * (DW / 8));
    return {b, b};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [STW-1:0] act, input logic [STW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic push_cmd(input logic [31:0] a, input logic [5:0] l);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_len = l;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic beat(input logic [DW-1:0] d, input logic [2:0] fl, input bit clr);
    @(negedge clk);
    rd_valid = 1'b1; rd_data = d; clr_err = clr;
    {rdq_empty, wrq_full, cmdq_full} = fl;
    @(negedge clk);
    rd_valid = 1'b0; clr_err = 1'b0;
  endtask

  task automatic good_beat(input logic [31:0] a, input int k, input string req);
    beat(model(a, k), 3'b000, 1'b0);
    chk(exp_valid && exp_data == model(a, k), req, STW'(exp_data), STW'(model(a, k)));
    chk(!beat_mismatch, "R2 match", STW'(beat_mismatch), 0);
  endtask

  logic [STW-1:0] st_exp;

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!exp_valid && !beat_mismatch && !err_flag, "R9 flags", {exp_valid, beat_mismatch, err_flag}, 0);
    chk(err_status == '0, "R9 status", err_status, 0);
    rst_n = 1'b1;
    // R4: beat with nothing pending
    beat(64'h1234, 3'b000, 1'b0);
    chk(!exp_valid && !beat_mismatch, "R4 idle beat", {exp_valid, beat_mismatch}, 0);

    // R1 sweep over lengths and addresses, including 32-bit wrap
    for (int l = 1; l <= 5; l++) begin
      for (int ai = 0; ai < 3; ai++) begin
        logic [31:0] a = (ai == 0) ? 32'(l * 32'h100) : (ai == 1) ? 32'hFFFF_FFF0 : 32'h8000_0008;
        push_cmd(a, 6'(l));
        for (int k = 0; k < l; k++) good_beat(a, k, "R1 sweep");
        beat(64'h0, 3'b000, 1'b0);
        chk(!exp_valid, "R3 burst ends after length", STW'(exp_valid), 0);
      end
    end
    chk(!err_flag, "R5 no error on clean data", STW'(err_flag), 0);

    // R3 ordering with two queued bursts
    push_cmd(32'h0000_1000, 6'd2);
    push_cmd(32'h0000_2000, 6'd1);
    good_beat(32'h1000, 0, "R3 order a0");
    good_beat(32'h1000, 1, "R3 order a1");
    good_beat(32'h2000, 0, "R3 order b0");

    // R3 length field 0 = 64 beats
    push_cmd(32'h0003_0000, 6'd0);
    for (int k = 0; k < 64; k++) good_beat(32'h0003_0000, k, "R3 len0");
    beat(64'h0, 3'b000, 1'b0);
    chk(!exp_valid, "R3 len0 is 64 beats", STW'(exp_valid), 0);

    // R5/R6 first error capture
    push_cmd(32'h0000_4000, 6'd3);
    good_beat(32'h4000, 0, "R1 pre-error");
    beat(model(32'h4000, 1) ^ 64'h1, 3'b101, 1'b0);
    chk(beat_mismatch && exp_valid, "R2 mismatch", {exp_valid, beat_mismatch}, 2'b11);
    chk(err_flag, "R5 flag rises", STW'(err_flag), 1);
    st_exp = {model(32'h4000, 1) ^ 64'h1, model(32'h4000, 1), 21'b0, 3'b101, 2'b0, 6'd3, 32'h0000_4000};
    chk(err_status == st_exp, "R6 status", err_status, st_exp);
    // R7 second mismatch does not alter status
    beat(64'hDEAD, 3'b010, 1'b0);
    chk(beat_mismatch, "R2 second mismatch", STW'(beat_mismatch), 1);
    chk(err_flag && err_status == st_exp, "R7 status held", err_status, st_exp);
    // R8 clear
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
    chk(!err_flag && err_status == '0, "R8 clear", err_status, 0);

    // R8 clear wins over simultaneous mismatch
    push_cmd(32'h0000_5000, 6'd1);
    beat(64'h7, 3'b111, 1'b1);
    chk(beat_mismatch, "R8 mismatch still shown", STW'(beat_mismatch), 1);
    chk(!err_flag && err_status == '0, "R8 clear priority", err_status, 0);

    // R5/R6 fresh capture after clear
    push_cmd(32'h0000_6000, 6'd2);
    good_beat(32'h6000, 0, "R1 post-clear");
    beat(64'h0, 3'b010, 1'b0);
    st_exp = {64'h0, model(32'h6000, 1), 21'b0, 3'b010, 2'b0, 6'd2, 32'h0000_6000};
    chk(err_flag && err_status == st_exp, "R6 recapture", err_status, st_exp);
    // R5 sticky across idle cycles
    repeat (4) @(negedge clk);
    chk(err_flag && err_status == st_exp, "R5 sticky", err_status, st_exp);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule